// File: doc/BRIEF.md
# PCI Target to Wishbone Bridge

This block is a minimal 32-bit PCI target. It turns accesses to one memory window into single Wishbone master cycles. It watches the multiplexed address/data bus and the command/byte-enable lines, and it claims two kinds of access:

- configuration transactions aimed at it through the chip-select input;
- memory transactions whose top address bits match its programmable base register.

The bridge holds a small type-0 configuration header. It contains fixed vendor, device and class identifiers, a command/status dword and one 32-bit memory base register.

Memory reads finish inside the PCI data phase that asked for them. The target-ready strobe stays high until the Wishbone slave acknowledges, and then it is driven low with the returned word. The bridge never asks the master to retry. Memory writes are passed through the same way. A transaction that ends can be followed at once by the next address phase.

Byte enables shape configuration writes only. Memory traffic always moves full 32-bit words. The bridge has no interrupt logic.

Top module: `pci_wb_bridge`

## Requirements
- R1: After reset, the three target strobes (device select, target ready, stop) are high, the address/data and parity drivers are off, and the Wishbone cycle and strobe are low. The memory-enable bit (command bit 1) and the base register both read zero.
- R2: Configuration reads return these dwords, selected by AD[7:2]:
  - dword 0: {device ID, vendor ID};
  - dword 1: {16'h0200, command}, where the command reads 0 except bit 1, which holds the memory enable;
  - dword 2: the class/revision parameter;
  - dword 4: the base register;
  - every other dword, including the one holding the interrupt pin, reads zero.
- R3: A configuration write changes only the bytes whose active-low enable is 0. Enable bit n guards AD[8n+7:8n].
- R4: The base register keeps its low WIN_BITS bits at zero. Writing all ones and reading it back gives 32'hFF000000 for the default 16 MB window. Bits 3:0 read 0000, meaning a 32-bit, non-prefetchable memory range.
- R5: An access is claimed only in these two cases; any other access leaves device select high and starts no Wishbone cycle:
  - configuration: IDSEL is high, the command is 1010 (read) or 1011 (write), and AD[1:0] is 00;
  - memory: the command is 0110 (read) or 0111 (write), memory enable is set, and AD[31:24] equals the base register's top byte.
- R6: Device select uses medium timing. It is still high after the address edge, and it is first seen low at the second rising edge after that edge. Target ready is never low while device select is high.
- R7: A memory read issues a single Wishbone read with address AD[23:2] and select 1111. Target ready stays high until the acknowledge arrives and goes low one clock later with the Wishbone data on AD. With a slave of L wait states, this is 2+L clocks after device select first shows low.
- R8: A memory write issues a single Wishbone write carrying the whole data-phase word, with select 1111 whatever the byte enables are. Target ready goes low 3+L clocks after device select first shows low.
- R9: If FRAME# is still low when target ready is asserted, stop goes low on the same edge. Stop and device select stay low until FRAME# is seen high, and then both return high.
- R10: A new address phase driven on the clock right after the final data phase is decoded and served normally.
- R11: One clock after a read data phase, the bridge drives PAR so that AD and C/BE# together with PAR have even parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus as seen at the pins |
| ad_o | output | 32 | Read data driven towards the bus |
| ad_oe | output | 1 | Output enable for ad_o |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| frame_n | input | 1 | Master frame strobe |
| irdy_n | input | 1 | Master ready |
| idsel | input | 1 | Configuration chip select |
| trdy_n_o | output | 1 | Target ready |
| devsel_n_o | output | 1 | Device select |
| stop_n_o | output | 1 | Stop request to the master |
| par_o | output | 1 | Even parity over AD and C/BE# |
| par_oe | output | 1 | Output enable for par_o |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | WIN_BITS-2 | Wishbone word address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Two pairs of events can land on one clock edge.

The first pair is the Wishbone acknowledge and a master that still holds FRAME# low. On that edge target ready and stop must fall together. Bursts are run against slaves with zero to three wait states, and the bench checks stop and target ready at that edge and the release once FRAME# rises.

The second pair is the end of one transaction and the start of the next. The bench drives a new address phase on the clock right after the final data phase. It then judges that the fresh access is claimed with the usual device-select timing, and that it returns data written by the transaction just before it.

// File: rtl/pci_wb_bridge.sv
module pci_wb_bridge #(
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID = 16'h0A21,
  parameter logic [31:0] CLASS_REV = 32'h05800001,
  parameter int          WIN_BITS  = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           ad_i,
  output logic [31:0]           ad_o,
  output logic                  ad_oe,
  input  logic [3:0]            cbe_n,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  input  logic                  idsel,
  output logic                  trdy_n_o,
  output logic                  devsel_n_o,
  output logic                  stop_n_o,
  output logic                  par_o,
  output logic                  par_oe,
  output logic                  wb_cyc_o,
  output logic                  wb_stb_o,
  output logic                  wb_we_o,
  output logic [WIN_BITS-3:0]   wb_adr_o,
  output logic [31:0]           wb_dat_o,
  output logic [3:0]            wb_sel_o,
  input  logic [31:0]           wb_dat_i,
  input  logic                  wb_ack_i
);
  localparam int HI_W = 32 - WIN_BITS;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_DATA, S_TURN, S_SKIP} state_t;
  state_t state;

  logic            frame_q, is_cfg, is_wr, wr_sent, mem_en;
  logic [31:0]     addr_q;
  logic [HI_W-1:0] bar_hi;
  logic [31:0]     bar_full, cfg_rdata, bar_merged;

  wire addr_phase = (state == S_IDLE) && !frame_n && frame_q;
  wire cfg_hit    = idsel && (cbe_n[3:1] == 3'b101) && (ad_i[1:0] == 2'b00);
  wire mem_hit    = (cbe_n[3:1] == 3'b011) && mem_en && (ad_i[31:WIN_BITS] == bar_hi);
  wire xfer       = (state == S_DATA) && !irdy_n && !trdy_n_o;

  assign bar_full = {bar_hi, {WIN_BITS{1'b0}}};
  assign wb_adr_o = addr_q[WIN_BITS-1:2];
  assign wb_sel_o = 4'hF;

  always_comb begin
    case (addr_q[7:2])
      6'd0:    cfg_rdata = {DEVICE_ID, VENDOR_ID};
      6'd1:    cfg_rdata = {16'h0200, 14'b0, mem_en, 1'b0};
      6'd2:    cfg_rdata = CLASS_REV;
      6'd4:    cfg_rdata = bar_full;
      default: cfg_rdata = 32'h0;
    endcase
  end

  for (genvar b = 0; b < 4; b++) begin : g_merge
    assign bar_merged[8*b +: 8] = cbe_n[b] ? bar_full[8*b +: 8] : ad_i[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      frame_q    <= 1'b1;
      is_cfg     <= 1'b0;
      is_wr      <= 1'b0;
      wr_sent    <= 1'b0;
      mem_en     <= 1'b0;
      addr_q     <= '0;
      bar_hi     <= '0;
      trdy_n_o   <= 1'b1;
      devsel_n_o <= 1'b1;
      stop_n_o   <= 1'b1;
      ad_o       <= '0;
      ad_oe      <= 1'b0;
      par_o      <= 1'b0;
      par_oe     <= 1'b0;
      wb_cyc_o   <= 1'b0;
      wb_stb_o   <= 1'b0;
      wb_we_o    <= 1'b0;
      wb_dat_o   <= '0;
    end else begin
      frame_q <= frame_n;
      par_o   <= ^{ad_o, cbe_n};
      par_oe  <= ad_oe;
      case (state)
        S_IDLE: begin
          wr_sent <= 1'b0;
          if (addr_phase) begin
            if (cfg_hit || mem_hit) begin
              state  <= S_DEC;
              is_cfg <= cfg_hit;
              is_wr  <= cbe_n[0];
              addr_q <= ad_i;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        S_DEC: begin
          devsel_n_o <= 1'b0;
          state      <= S_DATA;
          if (!is_wr) ad_oe <= 1'b1;
          if (is_cfg) begin
            trdy_n_o <= 1'b0;
            stop_n_o <= frame_n;
            if (!is_wr) ad_o <= cfg_rdata;
          end else if (!is_wr) begin
            wb_cyc_o <= 1'b1;
            wb_stb_o <= 1'b1;
            wb_we_o  <= 1'b0;
          end
        end
        S_DATA: begin
          if (wb_cyc_o) begin
            if (wb_ack_i) begin
              wb_cyc_o <= 1'b0;
              wb_stb_o <= 1'b0;
              trdy_n_o <= 1'b0;
              stop_n_o <= frame_n;
              if (!is_wr) ad_o <= wb_dat_i;
            end
          end else if (!is_cfg && is_wr && !wr_sent && !irdy_n) begin
            wb_cyc_o <= 1'b1;
            wb_stb_o <= 1'b1;
            wb_we_o  <= 1'b1;
            wb_dat_o <= ad_i;
            wr_sent  <= 1'b1;
          end
          if (xfer) begin
            trdy_n_o <= 1'b1;
            ad_oe    <= 1'b0;
            wr_sent  <= 1'b0;
            if (is_cfg && is_wr) begin
              if (addr_q[7:2] == 6'd1 && !cbe_n[0]) mem_en <= ad_i[1];
              if (addr_q[7:2] == 6'd4) bar_hi <= bar_merged[31:WIN_BITS];
            end
            if (frame_n) begin
              devsel_n_o <= 1'b1;
              stop_n_o   <= 1'b1;
              state      <= S_IDLE;
            end else begin
              state <= S_TURN;
            end
          end
        end
        S_TURN: begin
          if (frame_n) begin
            devsel_n_o <= 1'b1;
            stop_n_o   <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_SKIP: if (frame_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_stb_in_cyc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb_o |-> wb_cyc_o);
  assert_cyc_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i) |=> wb_cyc_o);
  assert_read_waits_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_we_o) |-> trdy_n_o);
  assert_trdy_needs_devsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_o |-> !devsel_n_o);
  assert_devsel_medium_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_o) |-> !$past(frame_n, 2));
  assert_stop_with_trdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n_o) |-> $fell(trdy_n_o));
endmodule

// File: tb/tb_pci_wb_bridge.sv
`timescale 1ns/1ps
module tb_pci_wb_bridge;
  localparam logic [15:0] VEN = 16'h13A7;
  localparam logic [15:0] DEV = 16'h0B44;
  localparam logic [31:0] CLS = 32'h11800003;

  logic clk = 0, rst_n = 0;
  logic [31:0] ad_m = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic frame_n = 1, irdy_n = 1, idsel = 0;
  logic [31:0] ad_o;
  logic ad_oe, trdy_n_o, devsel_n_o, stop_n_o, par_o, par_oe;
  logic wb_cyc_o, wb_stb_o, wb_we_o;
  logic [21:0] wb_adr_o;
  logic [31:0] wb_dat_o;
  logic [3:0]  wb_sel_o;
  logic [31:0] wb_dat_i = '0;
  logic wb_ack_i = 0;

  always #4 clk = ~clk;

  pci_wb_bridge #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_REV(CLS), .WIN_BITS(24)) dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_m), .ad_o(ad_o), .ad_oe(ad_oe), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel), .trdy_n_o(trdy_n_o),
    .devsel_n_o(devsel_n_o), .stop_n_o(stop_n_o), .par_o(par_o), .par_oe(par_oe),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i));

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0;
  logic [31:0] mem [64];
  logic [21:0] s_adr;
  logic [31:0] s_dat;
  logic [3:0]  s_sel;
  logic s_we;

  always @(posedge clk) begin
    if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
      if (wcnt >= lat) begin
        wb_ack_i <= 1'b1;
        wcnt <= 0;
        s_adr <= wb_adr_o; s_we <= wb_we_o; s_sel <= wb_sel_o; s_dat <= wb_dat_o;
        if (wb_we_o) mem[wb_adr_o[5:0]] <= wb_dat_o;
        else wb_dat_i <= mem[wb_adr_o[5:0]];
      end else wcnt <= wcnt + 1;
    end else wb_ack_i <= 1'b0;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic g_dev1, g_claim, g_nowb, g_stop, g_hold, g_rel, g_par, g_paroe, g_oe;
  logic [31:0] g_rdata;
  int g_wait;

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                     input logic [31:0] wdata, input logic [3:0] be, input logic burst, input logic b2b);
    if (!b2b) @(negedge clk);
    frame_n = 0; irdy_n = 1; ad_m = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    g_dev1 = devsel_n_o;
    frame_n = !burst; irdy_n = 0; idsel = 0; cbe_n = be; ad_m = wdata;
    @(negedge clk);
    g_claim = !devsel_n_o;
    g_wait = 0; g_stop = 0; g_rdata = '0; g_nowb = 1;
    if (!g_claim) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (!devsel_n_o || wb_cyc_o) g_nowb = 0;
      end
      frame_n = 1; irdy_n = 1;
    end else begin
      while (trdy_n_o && g_wait < 60) begin
        @(negedge clk);
        g_wait++;
      end
      g_rdata = ad_o; g_oe = ad_oe; g_stop = !stop_n_o;
      @(negedge clk);
      g_par = par_o; g_paroe = par_oe;
      if (burst) begin
        g_hold = !stop_n_o && trdy_n_o && !devsel_n_o;
        frame_n = 1;
        @(negedge clk);
        g_rel = devsel_n_o && stop_n_o;
        irdy_n = 1;
      end else begin
        g_hold = 1;
        g_rel = devsel_n_o && stop_n_o;
        irdy_n = 1;
      end
    end
  endtask

  function automatic logic [31:0] cfg_exp(input int idx, input logic men, input logic [7:0] bar);
    case (idx)
      0: return {DEV, VEN};
      1: return {16'h0200, 14'b0, men, 1'b0};
      2: return CLS;
      4: return {bar, 24'h0};
      default: return 32'h0;
    endcase
  endfunction

  logic       m_en = 0;
  logic [7:0] m_bar = 8'h00;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(devsel_n_o && trdy_n_o && stop_n_o, "R1 strobes", {devsel_n_o, trdy_n_o, stop_n_o}, 3'b111);
    chk(!ad_oe && !par_oe && !wb_cyc_o && !wb_stb_o, "R1 drivers", {ad_oe, par_oe, wb_cyc_o, wb_stb_o}, 0);

    // R1 and R2: sweep of all 16 header dwords after reset
    for (int idx = 0; idx < 16; idx++) begin
      txn(4'hA, {24'h0, idx[5:0], 2'b00}, 1, 0, 4'h0, 0, 0);
      chk(g_claim && g_dev1, "R6 devsel timing", {g_dev1, g_claim}, 2'b11);
      chk(g_rdata == cfg_exp(idx, 0, 0), idx == 1 || idx == 4 ? "R1 reset regs" : "R2 header",
          g_rdata, cfg_exp(idx, 0, 0));
      chk(g_wait == 0 && g_oe, "R2 config wait", g_wait, 0);
      chk(g_paroe && g_par == ^{g_rdata, 4'h0}, "R11 parity", {g_paroe, g_par}, {1'b1, ^g_rdata});
      chk(g_rel, "R6 release", g_rel, 1);
    end

    // R3: every byte-enable pattern on the base register
    for (int be = 0; be < 16; be++) begin
      txn(4'hB, 32'h10, 1, 32'h0, 4'h0, 0, 0);
      txn(4'hB, 32'h10, 1, 32'hA5C30F11, be[3:0], 0, 0);
      txn(4'hA, 32'h10, 1, 0, 4'h0, 0, 0);
      chk(g_rdata == (be[3] ? 32'h0 : 32'hA5000000), "R3 byte enable", g_rdata, be[3] ? 32'h0 : 32'hA5000000);
    end

    // R4: sizing
    txn(4'hB, 32'h10, 1, 32'hFFFFFFFF, 4'h0, 0, 0);
    txn(4'hA, 32'h10, 1, 0, 4'h0, 0, 0);
    chk(g_rdata == 32'hFF000000, "R4 sizing", g_rdata, 32'hFF000000);

    // R3: command byte guarded by its enable
    txn(4'hB, 32'h04, 1, 32'h2, 4'hF, 0, 0);
    txn(4'hA, 32'h04, 1, 0, 4'h0, 0, 0);
    chk(g_rdata == cfg_exp(1, 0, 0), "R3 masked command", g_rdata, cfg_exp(1, 0, 0));
    txn(4'hB, 32'h04, 1, 32'h2, 4'hE, 0, 0);
    m_en = 1;
    txn(4'hA, 32'h04, 1, 0, 4'h0, 0, 0);
    chk(g_rdata == cfg_exp(1, 1, 0), "R3 command write", g_rdata, cfg_exp(1, 1, 0));
    txn(4'hB, 32'h10, 1, 32'h5A000000, 4'h0, 0, 0);
    m_bar = 8'h5A;

    // R5: claim sweep over every command and both IDSEL levels
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 2; s++) begin
        logic exp_c;
        exp_c = (s == 1 && (c == 10 || c == 11)) || c == 6 || c == 7;
        txn(c[3:0], 32'h5A000010, s[0], 32'h5A000000, 4'h0, 0, 0);
        chk(g_claim == exp_c, "R5 claim", g_claim, exp_c);
        if (!exp_c) chk(g_nowb, "R5 no wishbone", g_nowb, 1);
      end
    txn(4'h6, 32'h5B000010, 0, 0, 4'h0, 0, 0);
    chk(!g_claim && g_nowb, "R5 outside window", g_claim, 0);

    // R7 and R8: memory traffic with zero to three slave wait states
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, d;
      a = 32'h5A000000 + (i << 2) + (i << 20) + (i % 4);
      d = 32'hC0DE0000 ^ (i * 32'h01010101);
      lat = i % 4;
      txn(4'h7, a, 0, d, i[3:0], 0, 0);
      chk(g_wait == 3 + lat, "R8 write timing", g_wait, 3 + lat);
      chk(s_we && s_sel == 4'hF && s_dat == d, "R8 full word", s_dat, d);
      chk(s_adr == a[23:2], "R8 address", {10'h0, s_adr}, {10'h0, a[23:2]});
      txn(4'h6, a, 0, 0, 4'h5, 0, 0);
      chk(g_wait == 2 + lat, "R7 read timing", g_wait, 2 + lat);
      chk(g_rdata == d, "R7 read data", g_rdata, d);
      chk(!s_we && s_sel == 4'hF && s_adr == a[23:2], "R7 wishbone read", {s_we, s_sel}, 5'h0F);
      chk(g_paroe && g_par == ^{d, 4'h5}, "R11 memory parity", g_par, ^{d, 4'h5});
    end

    // R9: bursts end with disconnect on the first data phase
    for (int l = 0; l < 4; l++) begin
      lat = l;
      txn(4'h6, 32'h5A000008, 0, 0, 4'h0, 1, 0);
      chk(g_stop && g_hold && g_rel, "R9 memory burst", {g_stop, g_hold, g_rel}, 3'b111);
      chk(g_rdata == mem[2], "R9 burst data", g_rdata, mem[2]);
    end
    txn(4'hA, 32'h0, 1, 0, 4'h0, 1, 0);
    chk(g_stop && g_hold && g_rel, "R9 config burst", {g_stop, g_hold, g_rel}, 3'b111);
    lat = 1;
    txn(4'h6, 32'h5A000008, 0, 0, 4'h0, 0, 0);
    chk(!g_stop, "R9 single no stop", g_stop, 0);

    // R10: back-to-back transactions
    txn(4'h7, 32'h5A00003C, 0, 32'h600DF00D, 4'h0, 0, 0);
    txn(4'h6, 32'h5A00003C, 0, 0, 4'h0, 0, 1);
    chk(g_claim && g_dev1 && g_rdata == 32'h600DF00D, "R10 memory", g_rdata, 32'h600DF00D);
    txn(4'hB, 32'h04, 1, 32'h0, 4'h0, 0, 1);
    m_en = 0;
    txn(4'hA, 32'h04, 1, 0, 4'h0, 0, 1);
    chk(g_claim && g_rdata == cfg_exp(1, 0, m_bar), "R10 config", g_rdata, cfg_exp(1, 0, m_bar));
    txn(4'h6, 32'h5A00003C, 0, 0, 4'h0, 0, 1);
    chk(!g_claim && g_nowb, "R5 memory disabled", g_claim, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule